// File: doc/BRIEF.md
# Memory Type Resolver

This block turns a physical address into an 8-bit cacheability type by consulting a snapshot of range-register state. The state is a global enable, an enable for the fixed low-memory table, a default type byte, a table of 88 type bytes covering the first megabyte, and a parameterised set of variable base/mask pairs. The answer for a request is registered and appears one clock after the request strobe.

The first megabyte is split into three zones with different granularity: 64 KiB steps below 512 KiB, 16 KiB steps up to 768 KiB, and 4 KiB steps up to 1 MiB. Above that boundary, or when the fixed table is switched off, every active variable range is compared against the address in parallel. When ranges overlap, a fixed precedence rule settles the result instead of a priority order. When no range hits, the default type is used.

Top module: `memtype_resolver`

## Requirements
- R1: When `cfg_enable` is 0, the response type is 0 (uncacheable) for every address, whatever the other state holds.
- R2: With both enables set and the address below 0x80000, the type is fixed byte number `addr>>16` (0..7). Fixed byte k sits at bits [8k+7:8k] of `fixed_types`.
- R3: With both enables set and the address in 0x80000..0xBFFFF, the type is fixed byte `8 + ((addr-0x80000)>>14)`.
- R4: With both enables set and the address in 0xC0000..0xFFFFF, the type is fixed byte `24 + ((addr-0xC0000)>>12)`.
- R5: At or above 0x100000, or with `cfg_fixed_enable` at 0, the fixed table is not used and the variable ranges or the default decide the result.
- R6: Variable pair i (base at bits [64i+63:64i] of `var_base`, mask likewise in `var_mask`) takes part only when bit 11 of its mask word is 1.
- R7: An active pair hits when address bits [ADDR_W-1:12] ANDed with mask bits [ADDR_W-1:12] equal the base bits ANDed with the same mask bits. Address bits 11..0 and base bits 11..8 play no part. The type of a pair is its base bits [7:0].
- R8: If every hitting pair has the same type, that type is the result.
- R9: If any hitting pair has type 0 (UC), the result is 0.
- R10: When the hit types differ, include no UC, and are all 4 (WT) or 6 (WB), the result is 4. Any other differing set gives 6. The other type codes are WC=1 and WP=5.
- R11: If no active pair hits, the result is `cfg_default_type`.
- R12: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid` at 1, and it carries that request's type. Without a request, `rsp_type` holds its value. After reset, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Physical address to classify |
| cfg_enable | input | 1 | Global range-register enable |
| cfg_fixed_enable | input | 1 | Fixed low-memory table enable |
| cfg_default_type | input | 8 | Type used when nothing else applies |
| fixed_types | input | 704 | 88 fixed type bytes, byte k at [8k+7:8k] |
| var_base | input | 64*NUM_VAR | Variable base words, type in low byte |
| var_mask | input | 64*NUM_VAR | Variable mask words, bit 11 enables |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_type | output | 8 | Resolved memory type |

## Verification
Every result is due exactly one clock after the edge that samples its request, and back-to-back requests give back-to-back results. The driver tags each expected type with the cycle number in which it is due. The monitor compares at the falling edge of that cycle and treats an early, late or missing `rsp_valid` as a failure. The configuration is changed only at the same falling edge at which a request is presented, so each expected value matches the state the design samples.

// File: rtl/memtype_pkg.sv
package memtype_pkg;
  localparam int REG_W      = 64;
  localparam int FIX_BYTES  = 88;
  localparam int PAGE_SHIFT = 12;
  localparam int RANGE_EN_BIT = 11;
  typedef logic [7:0] mtype_t;
  localparam mtype_t MT_UC = 8'd0;
  localparam mtype_t MT_WC = 8'd1;
  localparam mtype_t MT_WT = 8'd4;
  localparam mtype_t MT_WP = 8'd5;
  localparam mtype_t MT_WB = 8'd6;
endpackage

// File: rtl/memtype_rst_sync.sv
module memtype_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/memtype_fixed_lookup.sv
module memtype_fixed_lookup
  import memtype_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [FIX_BYTES*8-1:0]    fixed_types,
  output logic                      in_zone,
  output mtype_t                    fix_type
);
  localparam int ZONE_BIT = 20;
  localparam logic [6:0] MID_BASE  = 7'd8;
  localparam logic [6:0] FINE_BASE = 7'd24;

  logic [6:0] idx;

  always_comb begin
    in_zone = (addr[ADDR_W-1:ZONE_BIT] == '0);
    if (!addr[19])
      idx = {4'd0, addr[18:16]};
    else if (!addr[18])
      idx = MID_BASE + {3'd0, addr[17:14]};
    else
      idx = FINE_BASE + {1'b0, addr[17:12]};
    fix_type = fixed_types[int'(idx)*8 +: 8];
  end

  assert_idx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_zone |-> (idx < 7'(FIX_BYTES)));
  assert_mid_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_zone && addr[19:18] == 2'b10) |-> (idx >= 7'd8 && idx < 7'd24));
endmodule

// File: rtl/memtype_var_match.sv
module memtype_var_match
  import memtype_pkg::*;
#(
  parameter int ADDR_W  = 40,
  parameter int NUM_VAR = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NUM_VAR*REG_W-1:0]   var_base,
  input  logic [NUM_VAR*REG_W-1:0]   var_mask,
  output logic [NUM_VAR-1:0]         hit,
  output logic [NUM_VAR*8-1:0]       hit_type
);
  localparam int PG_W = ADDR_W - PAGE_SHIFT;

  logic [NUM_VAR-1:0] active;
  logic [PG_W-1:0]    addr_pg;

  assign addr_pg = addr[ADDR_W-1:PAGE_SHIFT];

  for (genvar g = 0; g < NUM_VAR; g++) begin : g_pair
    logic [PG_W-1:0] base_pg;
    logic [PG_W-1:0] mask_pg;
    always_comb begin
      base_pg   = var_base[g*REG_W+PAGE_SHIFT +: PG_W];
      mask_pg   = var_mask[g*REG_W+PAGE_SHIFT +: PG_W];
      active[g] = var_mask[g*REG_W+RANGE_EN_BIT];
      hit[g]    = active[g] && ((addr_pg & mask_pg) == (base_pg & mask_pg));
      hit_type[g*8 +: 8] = var_base[g*REG_W +: 8];
    end
  end

  assert_hits_within_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit) <= $countones(active));
endmodule

// File: rtl/memtype_precedence.sv
module memtype_precedence
  import memtype_pkg::*;
#(
  parameter int NUM_VAR = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_VAR-1:0]     hit,
  input  logic [NUM_VAR*8-1:0]   hit_type,
  input  mtype_t                 default_type,
  output mtype_t                 res_type
);
  logic   any_hit;
  logic   any_uc;
  logic   differ;
  logic   only_wt_wb;
  mtype_t first_type;
  mtype_t cur;

  always_comb begin
    any_hit    = 1'b0;
    any_uc     = 1'b0;
    differ     = 1'b0;
    only_wt_wb = 1'b1;
    first_type = MT_UC;
    cur        = MT_UC;
    for (int i = 0; i < NUM_VAR; i++) begin
      cur = hit_type[i*8 +: 8];
      if (hit[i]) begin
        if (!any_hit) first_type = cur;
        else if (cur != first_type) differ = 1'b1;
        any_hit = 1'b1;
        if (cur == MT_UC) any_uc = 1'b1;
        if (cur != MT_WT && cur != MT_WB) only_wt_wb = 1'b0;
      end
    end
    if (!any_hit)        res_type = default_type;
    else if (any_uc)     res_type = MT_UC;
    else if (!differ)    res_type = first_type;
    else if (only_wt_wb) res_type = MT_WT;
    else                 res_type = MT_WB;
  end

  assert_nohit_default_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0) |-> (res_type == default_type));
  assert_single_hit_type_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(hit) == 1 && !any_uc) |-> (res_type == first_type));
  assert_mixed_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (any_hit && differ && !any_uc) |-> (res_type == MT_WT || res_type == MT_WB));
endmodule

// File: rtl/memtype_resolver.sv
module memtype_resolver
  import memtype_pkg::*;
#(
  parameter int ADDR_W  = 40,
  parameter int NUM_VAR = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic                       cfg_enable,
  input  logic                       cfg_fixed_enable,
  input  logic [7:0]                 cfg_default_type,
  input  logic [FIX_BYTES*8-1:0]     fixed_types,
  input  logic [NUM_VAR*REG_W-1:0]   var_base,
  input  logic [NUM_VAR*REG_W-1:0]   var_mask,
  output logic                       rsp_valid,
  output logic [7:0]                 rsp_type
);
  logic               rst_sync_n;
  logic               in_zone;
  mtype_t             fix_type;
  mtype_t             var_type;
  mtype_t             sel_type;
  logic [NUM_VAR-1:0] hit;
  logic [NUM_VAR*8-1:0] hit_type;
  logic               valid_d;
  mtype_t             type_d;

  memtype_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  memtype_fixed_lookup #(.ADDR_W(ADDR_W)) u_fixed (
    .clk(clk), .rst_n(rst_sync_n), .addr(req_addr),
    .fixed_types(fixed_types), .in_zone(in_zone), .fix_type(fix_type)
  );

  memtype_var_match #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR)) u_match (
    .clk(clk), .rst_n(rst_sync_n), .addr(req_addr),
    .var_base(var_base), .var_mask(var_mask),
    .hit(hit), .hit_type(hit_type)
  );

  memtype_precedence #(.NUM_VAR(NUM_VAR)) u_prec (
    .clk(clk), .rst_n(rst_sync_n), .hit(hit), .hit_type(hit_type),
    .default_type(cfg_default_type), .res_type(var_type)
  );

  always_comb begin
    if (!cfg_enable)                       sel_type = MT_UC;
    else if (cfg_fixed_enable && in_zone)  sel_type = fix_type;
    else                                   sel_type = var_type;
    valid_d = req_valid;
    type_d  = req_valid ? sel_type : rsp_type;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_type  <= MT_UC;
    end else begin
      rsp_valid <= valid_d;
      rsp_type  <= type_d;
    end
  end

  assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid);
  assert_no_spurious_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> (!rsp_valid && $stable(rsp_type)));
  assert_disabled_uc_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !cfg_enable) |=> (rsp_type == MT_UC));
  assert_coarse_fixed_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && cfg_enable && cfg_fixed_enable && req_addr[ADDR_W-1:19] == '0)
      |=> (rsp_type == $past(fixed_types[int'(req_addr[18:16])*8 +: 8])));
  assert_high_not_fixed_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && cfg_enable && (!cfg_fixed_enable || req_addr[ADDR_W-1:20] != '0))
      |=> (rsp_type == $past(var_type)));
endmodule

// File: tb/memtype_resolver_test.sv
module memtype_resolver_test;
  localparam int AW = 40;
  localparam int NV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic cfg_enable = 1'b0, cfg_fixed_enable = 1'b0;
  logic [7:0] cfg_default_type = '0;
  logic [703:0] fixed_types = '0;
  logic [NV*64-1:0] var_base = '0, var_mask = '0;
  logic rsp_valid;
  logic [7:0] rsp_type;

  memtype_resolver #(.ADDR_W(AW), .NUM_VAR(NV)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .cfg_enable(cfg_enable), .cfg_fixed_enable(cfg_fixed_enable),
    .cfg_default_type(cfg_default_type), .fixed_types(fixed_types),
    .var_base(var_base), .var_mask(var_mask),
    .rsp_valid(rsp_valid), .rsp_type(rsp_type)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0, mon_on = 0;

  // staged configuration, applied together with each request
  logic s_en, s_fen;
  logic [7:0] s_def;
  logic [7:0] s_fx [88];
  logic [63:0] s_base [NV];
  logic [63:0] s_mask [NV];

  typedef struct { logic [7:0] t; int due; string tag; } exp_t;
  exp_t q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_mask(input int size_log2, input bit en);
    logic [63:0] m;
    m = ((~64'd0) << size_log2) & ((64'd1 << AW) - 1);
    m[11] = en;
    return m;
  endfunction

  function automatic logic [7:0] ref_type(input logic [AW-1:0] a);
    logic [7:0] t, first;
    bit any, uc, diff, wtwb;
    logic [AW-1:0] pm;
    if (!s_en) return 8'd0;
    if (s_fen && a < 40'h100000) begin
      if (a < 40'h80000) return s_fx[int'(a >> 16)];
      if (a < 40'hC0000) return s_fx[8 + int'((a - 40'h80000) >> 14)];
      return s_fx[24 + int'((a - 40'hC0000) >> 12)];
    end
    any = 0; uc = 0; diff = 0; wtwb = 1; first = 0;
    for (int i = 0; i < NV; i++) begin
      if (!s_mask[i][11]) continue;
      pm = s_mask[i][AW-1:0] & ~40'hFFF;
      if ((a & pm) != (s_base[i][AW-1:0] & pm)) continue;
      t = s_base[i][7:0];
      if (!any) first = t; else if (t != first) diff = 1;
      any = 1;
      if (t == 8'd0) uc = 1;
      if (t != 8'd4 && t != 8'd6) wtwb = 0;
    end
    if (!any) return s_def;
    if (uc) return 8'd0;
    if (!diff) return first;
    return wtwb ? 8'd4 : 8'd6;
  endfunction

  task automatic issue(input logic [AW-1:0] a, input string tag);
    exp_t e;
    @(negedge clk);
    cfg_enable = s_en;
    cfg_fixed_enable = s_fen;
    cfg_default_type = s_def;
    for (int k = 0; k < 88; k++) fixed_types[k*8 +: 8] = s_fx[k];
    for (int k = 0; k < NV; k++) begin
      var_base[k*64 +: 64] = s_base[k];
      var_mask[k*64 +: 64] = s_mask[k];
    end
    req_addr = a;
    req_valid = 1'b1;
    e.t = ref_type(a); e.due = cyc + 1; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_addr = '0;
    end
  endtask

  task automatic clear_vars();
    for (int k = 0; k < NV; k++) begin s_base[k] = '0; s_mask[k] = '0; end
  endtask

  // monitor: compares each result in the cycle it is due
  always @(negedge clk) begin
    if (mon_on) begin
      if (q.size() != 0 && q[0].due == cyc) begin
        check(rsp_valid === 1'b1, {q[0].tag, " R12 valid"}, {7'd0, rsp_valid}, 8'd1);
        check(rsp_type === q[0].t, q[0].tag, rsp_type, q[0].t);
        void'(q.pop_front());
      end else if (rsp_valid !== 1'b0) begin
        check(1'b0, "R12 unexpected valid", {7'd0, rsp_valid}, 8'd0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    s_en = 0; s_fen = 0; s_def = 8'd6;
    for (int k = 0; k < 88; k++) s_fx[k] = 8'(k + 100);
    clear_vars();
    repeat (4) @(negedge clk);
    check(rsp_valid === 1'b0, "R12 reset valid", {7'd0, rsp_valid}, 8'd0);
    check(rsp_type === 8'd0, "R12 reset type", rsp_type, 8'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1;

    // R1: global disable
    s_fen = 1; s_base[0] = 64'h0000_0006; s_mask[0] = mk_mask(12, 1);
    issue(40'h0, "R1 low");
    issue(40'h12_3456_7000, "R1 high");
    idle(2);

    // R2/R3/R4: fixed zones
    s_en = 1; clear_vars();
    issue(40'h00000, "R2 idx0");
    issue(40'h3FFFF, "R2 idx3");
    issue(40'h7FFFF, "R2 idx7");
    issue(40'h80000, "R3 idx8");
    issue(40'hA4000, "R3 idx17");
    issue(40'hBFFFF, "R3 idx23");
    issue(40'hC0000, "R4 idx24");
    issue(40'hE5000, "R4 idx61");
    issue(40'hFFFFF, "R4 idx87");
    idle(2);
    check(rsp_valid === 1'b0, "R12 idle", {7'd0, rsp_valid}, 8'd0);

    // R5: fixed disabled or above 1 MiB
    s_def = 8'd5;
    issue(40'h100000, "R5 above");
    s_fen = 0;
    issue(40'h10000, "R5 fixdis");
    s_base[1] = 64'h0000_0001; s_mask[1] = mk_mask(20, 1);
    issue(40'h10000, "R5 fixdis var");
    idle(1);
    clear_vars();

    // R6/R7: enable bit and match
    s_base[0] = 64'h1000_0F06; s_mask[0] = mk_mask(28, 0);
    issue(40'h1234_5678, "R6 disabled pair");
    s_mask[0] = mk_mask(28, 1);
    issue(40'h1234_5678, "R6 enabled pair");
    issue(40'h1FFF_FFFF, "R7 top of range");
    issue(40'h2000_0000, "R7 past range");
    issue(40'h0FFF_FFFF, "R7 below range");
    idle(1);

    // R8: equal types overlap
    s_base[0] = 64'h1000_0001; s_base[3] = 64'h1000_0001; s_mask[3] = mk_mask(12, 1);
    issue(40'h1000_0000, "R8 same WC");
    // R9: UC among others
    s_base[5] = 64'h1000_0006; s_mask[5] = mk_mask(24, 1);
    s_base[7] = 64'h1000_0000; s_mask[7] = mk_mask(16, 1);
    issue(40'h1000_0000, "R9 UC wins");
    // R10: WT+WB, WC+WB, WP+WT
    clear_vars();
    s_base[2] = 64'h2000_0006; s_mask[2] = mk_mask(28, 1);
    s_base[6] = 64'h2000_0004; s_mask[6] = mk_mask(20, 1);
    issue(40'h2000_1000, "R10 WT+WB");
    s_base[6] = 64'h2000_0001;
    issue(40'h2000_1000, "R10 WC+WB");
    s_base[2] = 64'h2000_0005; s_base[6] = 64'h2000_0004;
    issue(40'h2000_1000, "R10 WP+WT");
    // R11: no hit
    s_def = 8'd1;
    issue(40'h3000_0000, "R11 default");
    idle(3);

    check(q.size() == 0, "R12 drained", 8'(q.size()), 8'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule